// File: doc/BRIEF.md
# Associative Sibling Search Array

This block holds a small table of tree-node codes, one code per processing slot. It answers sibling queries about a reference node. Each code is a string of digits. The first digit gives the child position at the top level, the next digit the position one level down, and so on. Unused levels are zero. Codes are written into the slots one after another. A query broadcasts a reference code to every slot in the same cycle. Each slot decides in parallel whether it is a sibling of the reference on the wanted side. Two pipelined reduction trees then pick the nearest sibling on each side.

Index queries return a bit mask with one bit per slot. They can mark the nearest right sibling, the nearest left sibling, or both together. Value queries return the full code of the nearest sibling on one side. Every query also returns a responder bit that says whether anything was found. A query takes the same number of cycles whatever the table size, and a new query may be issued on every cycle.

Top module: `asa_sibling_search`

## Requirements
- R1: Each cycle with `ld_valid` high writes `ld_code` into the next free slot and marks it valid, counting from slot 0. A load is ignored once all NSLOT slots are full. `ld_clear` empties the table and takes priority over a load in the same cycle.
- R2: A code has NDIG digits of DIGW bits each, with digit 0 (the top level) in the most significant bits. A code is a run of nonzero digits followed by zeros. Its depth is the number of nonzero digits, and its last digit is the deepest nonzero one.
- R3: A valid slot is a candidate when its depth equals the reference's depth and every digit except the last matches the reference. It is a right candidate when its last digit is greater than the reference's, and a left candidate when its last digit is smaller. An all-zero reference has no candidates.
- R4: Operation code 0 (next index) sets exactly the mask bit of the right candidate with the smallest last digit. Slot j maps to bit j, and a tie goes to the lowest slot.
- R5: Operation code 1 (previous index) sets exactly the mask bit of the left candidate with the largest last digit, and a tie goes to the lowest slot.
- R6: Operation code 2 (both-sibling index) sets the union of the R4 and R5 bits, so it flags at most two slots.
- R7: Operation codes 3 (next value) and 4 (previous value) return the code of the R4 or R5 winner with an all-zero mask.
- R8: The responder bit is high exactly when the operation found at least one result. A value operation that finds nothing returns an all-zero code.
- R9: A result appears with `res_valid` high exactly $clog2(NSLOT)+1 cycles after the clock edge that samples `op_valid`. Queries may be issued back to back, and each one yields exactly one result.
- R10: While `res_valid` is low, the mask, the code and the responder bit are all zero. Operation codes 5 to 7 return a valid result with no flags, a zero code and the responder bit low.
- R11: A query sees the table as it stood before any load or clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_clear | input | 1 | Empty the table and restart loading at slot 0 |
| ld_valid | input | 1 | Write `ld_code` into the next free slot |
| ld_code | input | NDIG*DIGW | Code to load |
| op_valid | input | 1 | Issue a query this cycle |
| op_kind | input | 3 | Query kind (0..4, see R4 to R7) |
| op_ref | input | NDIG*DIGW | Reference code broadcast to all slots |
| res_valid | output | 1 | Result present this cycle |
| res_flags | output | NSLOT | Per-slot result mask, slot j on bit j |
| res_code | output | NDIG*DIGW | Code found by a value query |
| res_found | output | 1 | Responder: at least one result |

## Verification
The assertions assume that every loaded code and every reference is well formed: a nonzero prefix followed only by zeros. Without that, depth and last digit have no meaning and the single-winner properties cannot be argued. The stimulus builds all codes through one helper that writes a random depth of one to three and fills only those levels with nonzero digits. The directed part uses hand-written codes that follow the same shape. Operation codes outside 0 to 4 are issued on purpose so that the idle-result rule can be checked.

// File: rtl/asa_pkg.sv
// Package: shared operation encoding for the sibling search array.
// Assumes: op_kind arrives as a 3-bit field; values 5..7 are unused.
package asa_pkg;
    typedef enum logic [2:0] {
        OP_NXT_IDX = 3'd0,
        OP_PRV_IDX = 3'd1,
        OP_SIB_IDX = 3'd2,
        OP_NXT_VAL = 3'd3,
        OP_PRV_VAL = 3'd4
    } asa_op_e;
endpackage

// File: rtl/asa_slot_bank.sv
// Module: asa_slot_bank
// Holds NSLOT codes with valid bits, filled in order from slot 0.
// Assumes: loads past the last slot are dropped; clear wins over load.
module asa_slot_bank #(
    parameter int NSLOT = 8,
    parameter int CW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_clear,
    input  logic                ld_valid,
    input  logic [CW-1:0]       ld_code,
    output logic [NSLOT*CW-1:0] slot_code,
    output logic [NSLOT-1:0]    slot_vld
);
    localparam int PW = $clog2(NSLOT + 1);

    logic [PW-1:0] fill_ptr;
    logic          can_load;

    assign can_load = ld_valid && !ld_clear && (fill_ptr < PW'(NSLOT));

    // Advance the fill pointer on each accepted load, rewind on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || ld_clear) begin
            fill_ptr <= '0;
        end else if (can_load) begin
            fill_ptr <= fill_ptr + PW'(1);
        end
    end

    for (genvar j = 0; j < NSLOT; j++) begin : g_slot
        logic [CW-1:0] code_q;
        logic          vld_q;

        // Capture the code when this slot is the one being filled.
        always_ff @(posedge clk) begin
            if (can_load && fill_ptr == PW'(j)) begin
                code_q <= ld_code;
            end
        end

        // Track occupancy of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n || ld_clear) begin
                vld_q <= 1'b0;
            end else if (can_load && fill_ptr == PW'(j)) begin
                vld_q <= 1'b1;
            end
        end

        assign slot_code[j*CW +: CW] = code_q;
        assign slot_vld[j]           = vld_q;
    end
endmodule

// File: rtl/asa_match.sv
// Module: asa_match
// Broadcast compare: every slot tests itself against the reference code
// in parallel and registers right/left candidate bits and its last digit.
// Assumes: codes are a nonzero prefix followed by zeros. Pad slots
// (NSLOT..P2-1) never match.
module asa_match #(
    parameter int NSLOT = 8,
    parameter int NDIG  = 4,
    parameter int DIGW  = 4,
    parameter int P2    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [NDIG*DIGW-1:0]   op_ref,
    input  logic [NSLOT*NDIG*DIGW-1:0] slot_code,
    input  logic [NSLOT-1:0]       slot_vld,
    output logic [P2-1:0]          nxt_hit,
    output logic [P2-1:0]          prv_hit,
    output logic [P2*DIGW-1:0]     hit_dig
);
    localparam int CW = NDIG * DIGW;

    int               ref_pos;
    logic             ref_deep;
    logic [DIGW-1:0]  ref_dig;

    // Locate the deepest nonzero digit of the reference.
    always_comb begin
        ref_pos  = 0;
        ref_deep = 1'b0;
        ref_dig  = '0;
        for (int k = 0; k < NDIG; k++) begin
            if (op_ref[CW-1-k*DIGW -: DIGW] != '0) begin
                ref_pos  = k;
                ref_deep = 1'b1;
                ref_dig  = op_ref[CW-1-k*DIGW -: DIGW];
            end
        end
    end

    for (genvar j = 0; j < P2; j++) begin : g_cmp
        if (j < NSLOT) begin : g_real
            logic [CW-1:0]   sc;
            logic            same_rest;
            logic [DIGW-1:0] sd;
            logic            nxt_q, prv_q;
            logic [DIGW-1:0] dig_q;

            assign sc = slot_code[j*CW +: CW];

            // Compare every digit except the last one and pick out the last.
            always_comb begin
                same_rest = 1'b1;
                sd        = '0;
                for (int k = 0; k < NDIG; k++) begin
                    if (k == ref_pos) begin
                        sd = sc[CW-1-k*DIGW -: DIGW];
                    end else if (sc[CW-1-k*DIGW -: DIGW] != op_ref[CW-1-k*DIGW -: DIGW]) begin
                        same_rest = 1'b0;
                    end
                end
            end

            // Register the candidate decision for the reduction trees.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    nxt_q <= 1'b0;
                    prv_q <= 1'b0;
                    dig_q <= '0;
                end else begin
                    nxt_q <= op_valid && slot_vld[j] && ref_deep && same_rest && (sd > ref_dig);
                    prv_q <= op_valid && slot_vld[j] && ref_deep && same_rest &&
                             (sd < ref_dig) && (sd != '0);
                    dig_q <= sd;
                end
            end

            assign nxt_hit[j]              = nxt_q;
            assign prv_hit[j]              = prv_q;
            assign hit_dig[j*DIGW +: DIGW] = dig_q;
        end else begin : g_pad
            assign nxt_hit[j]              = 1'b0;
            assign prv_hit[j]              = 1'b0;
            assign hit_dig[j*DIGW +: DIGW] = '0;
        end
    end
endmodule

// File: rtl/asa_reduce.sv
// Module: asa_reduce
// Pipelined binary tree choosing the hit leaf with the smallest
// (MAXSEL=0) or largest (MAXSEL=1) digit; a tie goes to the lower leaf.
// One register per tree level, so the latency is LVL cycles.
// Assumes: P2 = 2**LVL leaves, IW = max(1, LVL).
module asa_reduce #(
    parameter int P2     = 8,
    parameter int LVL    = 3,
    parameter int DIGW   = 4,
    parameter int IW     = 3,
    parameter bit MAXSEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [P2-1:0]     leaf_hit,
    input  logic [P2*DIGW-1:0] leaf_dig,
    output logic              root_hit,
    output logic [DIGW-1:0]   root_dig,
    output logic [IW-1:0]     root_idx
);
    if (LVL == 0) begin : g_flat
        assign root_hit = leaf_hit[0];
        assign root_dig = leaf_dig[DIGW-1:0];
        assign root_idx = '0;
    end else begin : g_tree
        localparam int NN = P2 - 1;
        logic [NN-1:0]      n_hit;
        logic [NN*DIGW-1:0] n_dig;
        logic [NN*IW-1:0]   n_idx;

        for (genvar i = 0; i < NN; i++) begin : g_node
            localparam int C0 = 2*i + 1;
            localparam int C1 = 2*i + 2;
            logic            a_h, b_h, take_a;
            logic [DIGW-1:0] a_d, b_d;
            logic [IW-1:0]   a_i, b_i;
            logic            h_q;
            logic [DIGW-1:0] d_q;
            logic [IW-1:0]   i_q;

            if (C0 >= NN) begin : g_leaves
                assign a_h = leaf_hit[C0-NN];
                assign a_d = leaf_dig[(C0-NN)*DIGW +: DIGW];
                assign a_i = IW'(C0-NN);
                assign b_h = leaf_hit[C1-NN];
                assign b_d = leaf_dig[(C1-NN)*DIGW +: DIGW];
                assign b_i = IW'(C1-NN);
            end else begin : g_inner
                assign a_h = n_hit[C0];
                assign a_d = n_dig[C0*DIGW +: DIGW];
                assign a_i = n_idx[C0*IW +: IW];
                assign b_h = n_hit[C1];
                assign b_d = n_dig[C1*DIGW +: DIGW];
                assign b_i = n_idx[C1*IW +: IW];
            end

            if (MAXSEL) begin : g_max
                assign take_a = a_h && (!b_h || a_d >= b_d);
            end else begin : g_min
                assign take_a = a_h && (!b_h || a_d <= b_d);
            end

            // Register the winner of this pair for the next level up.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    h_q <= 1'b0;
                    d_q <= '0;
                    i_q <= '0;
                end else begin
                    h_q <= a_h || b_h;
                    d_q <= take_a ? a_d : b_d;
                    i_q <= take_a ? a_i : b_i;
                end
            end

            assign n_hit[i]              = h_q;
            assign n_dig[i*DIGW +: DIGW] = d_q;
            assign n_idx[i*IW +: IW]     = i_q;
        end

        assign root_hit = n_hit[0];
        assign root_dig = n_dig[DIGW-1:0];
        assign root_idx = n_idx[IW-1:0];
    end
endmodule

// File: rtl/asa_sibling_search.sv
// Module: asa_sibling_search (top)
// Table of tree-node codes searched for the nearest right/left sibling of
// a broadcast reference. Fixed latency of $clog2(NSLOT)+1 cycles, one
// query per cycle.
// Assumes: codes are well formed (nonzero prefix, then zeros).
module asa_sibling_search #(
    parameter int NSLOT = 8,
    parameter int NDIG  = 4,
    parameter int DIGW  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_clear,
    input  logic                 ld_valid,
    input  logic [NDIG*DIGW-1:0] ld_code,
    input  logic                 op_valid,
    input  logic [2:0]           op_kind,
    input  logic [NDIG*DIGW-1:0] op_ref,
    output logic                 res_valid,
    output logic [NSLOT-1:0]     res_flags,
    output logic [NDIG*DIGW-1:0] res_code,
    output logic                 res_found
);
    import asa_pkg::*;

    localparam int CW  = NDIG * DIGW;
    localparam int LVL = $clog2(NSLOT);
    localparam int P2  = 1 << LVL;
    localparam int IW  = (LVL == 0) ? 1 : LVL;

    logic [NSLOT*CW-1:0] slot_code;
    logic [NSLOT-1:0]    slot_vld;
    logic [P2-1:0]       nxt_hit, prv_hit;
    logic [P2*DIGW-1:0]  hit_dig;
    logic                nx_h, pv_h;
    logic [DIGW-1:0]     nx_d, pv_d;
    logic [IW-1:0]       nx_i, pv_i;
    logic [NSLOT-1:0]    nx_mask, pv_mask;

    logic                pipe_v [LVL+1];
    logic [2:0]          pipe_k [LVL+1];
    logic [CW-1:0]       pipe_r [LVL+1];

    asa_slot_bank #(.NSLOT(NSLOT), .CW(CW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_clear (ld_clear),
        .ld_valid (ld_valid),
        .ld_code  (ld_code),
        .slot_code(slot_code),
        .slot_vld (slot_vld)
    );

    asa_match #(.NSLOT(NSLOT), .NDIG(NDIG), .DIGW(DIGW), .P2(P2)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_ref   (op_ref),
        .slot_code(slot_code),
        .slot_vld (slot_vld),
        .nxt_hit  (nxt_hit),
        .prv_hit  (prv_hit),
        .hit_dig  (hit_dig)
    );

    asa_reduce #(.P2(P2), .LVL(LVL), .DIGW(DIGW), .IW(IW), .MAXSEL(1'b0)) u_min (
        .clk     (clk),
        .rst_n   (rst_n),
        .leaf_hit(nxt_hit),
        .leaf_dig(hit_dig),
        .root_hit(nx_h),
        .root_dig(nx_d),
        .root_idx(nx_i)
    );

    asa_reduce #(.P2(P2), .LVL(LVL), .DIGW(DIGW), .IW(IW), .MAXSEL(1'b1)) u_max (
        .clk     (clk),
        .rst_n   (rst_n),
        .leaf_hit(prv_hit),
        .leaf_dig(hit_dig),
        .root_hit(pv_h),
        .root_dig(pv_d),
        .root_idx(pv_i)
    );

    // Carry the query kind and reference alongside the compare/reduce stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l <= LVL; l++) begin
                pipe_v[l] <= 1'b0;
                pipe_k[l] <= '0;
                pipe_r[l] <= '0;
            end
        end else begin
            pipe_v[0] <= op_valid;
            pipe_k[0] <= op_kind;
            pipe_r[0] <= op_ref;
            for (int l = 1; l <= LVL; l++) begin
                pipe_v[l] <= pipe_v[l-1];
                pipe_k[l] <= pipe_k[l-1];
                pipe_r[l] <= pipe_r[l-1];
            end
        end
    end

    for (genvar j = 0; j < NSLOT; j++) begin : g_mask
        assign nx_mask[j] = nx_h && (nx_i == IW'(j));
        assign pv_mask[j] = pv_h && (pv_i == IW'(j));
    end

    // Rebuild a full code from the reference with its last digit replaced.
    function automatic logic [CW-1:0] swap_last(input logic [CW-1:0] r,
                                                input logic [DIGW-1:0] d);
        int pos;
        logic [CW-1:0] o;
        pos = 0;
        for (int k = 0; k < NDIG; k++) begin
            if (r[CW-1-k*DIGW -: DIGW] != '0) pos = k;
        end
        o = r;
        for (int k = 0; k < NDIG; k++) begin
            if (k == pos) o[CW-1-k*DIGW -: DIGW] = d;
        end
        return o;
    endfunction

    // Form the result for the query leaving the pipeline; idle means zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_flags <= '0;
            res_code  <= '0;
            res_found <= 1'b0;
        end else begin
            res_valid <= pipe_v[LVL];
            res_flags <= '0;
            res_code  <= '0;
            res_found <= 1'b0;
            if (pipe_v[LVL]) begin
                case (pipe_k[LVL])
                    OP_NXT_IDX: begin
                        res_flags <= nx_mask;
                        res_found <= nx_h;
                    end
                    OP_PRV_IDX: begin
                        res_flags <= pv_mask;
                        res_found <= pv_h;
                    end
                    OP_SIB_IDX: begin
                        res_flags <= nx_mask | pv_mask;
                        res_found <= nx_h | pv_h;
                    end
                    OP_NXT_VAL: begin
                        res_code  <= nx_h ? swap_last(pipe_r[LVL], nx_d) : '0;
                        res_found <= nx_h;
                    end
                    OP_PRV_VAL: begin
                        res_code  <= pv_h ? swap_last(pipe_r[LVL], pv_d) : '0;
                        res_found <= pv_h;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/asa_sibling_search_chk.sv
// Module: asa_sibling_search_chk
// Property checker bound to the top. Keeps its own delay line of query
// valid/kind to know which result is due on which cycle.
// Assumes: LAT equals the top's pipeline latency.
module asa_sibling_search_chk #(
    parameter int NSLOT = 8,
    parameter int CW    = 16,
    parameter int LAT   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_kind,
    input logic             res_valid,
    input logic [NSLOT-1:0] res_flags,
    input logic [CW-1:0]    res_code,
    input logic             res_found
);
    logic       exp_v [LAT+1];
    logic [2:0] exp_k [LAT+1];
    logic       is_idx, is_val;

    // Delay the issued query so it lines up with its result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l <= LAT; l++) begin
                exp_v[l] <= 1'b0;
                exp_k[l] <= '0;
            end
        end else begin
            exp_v[0] <= op_valid;
            exp_k[0] <= op_kind;
            for (int l = 1; l <= LAT; l++) begin
                exp_v[l] <= exp_v[l-1];
                exp_k[l] <= exp_k[l-1];
            end
        end
    end

    assign is_idx = exp_v[LAT] && (exp_k[LAT] <= 3'd2);
    assign is_val = exp_v[LAT] && (exp_k[LAT] == 3'd3 || exp_k[LAT] == 3'd4);

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) res_valid == exp_v[LAT]); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !res_valid |-> (res_flags == '0 && res_code == '0 && !res_found)); // R10
    AST_NEXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (exp_v[LAT] && exp_k[LAT] == 3'd0) |-> $onehot0(res_flags)); // R4
    AST_PREV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (exp_v[LAT] && exp_k[LAT] == 3'd1) |-> $onehot0(res_flags)); // R5
    AST_SIB_PAIR: assert property (@(posedge clk) disable iff (!rst_n) (exp_v[LAT] && exp_k[LAT] == 3'd2) |-> ($countones(res_flags) <= 2)); // R6
    AST_VALUE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) is_val |-> (res_flags == '0)); // R7
    AST_RESPONDER_INDEX: assert property (@(posedge clk) disable iff (!rst_n) is_idx |-> (res_found == (res_flags != '0))); // R8
    AST_MISS_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n) (is_val && !res_found) |-> (res_code == '0)); // R8
    AST_UNUSED_KIND: assert property (@(posedge clk) disable iff (!rst_n) (exp_v[LAT] && exp_k[LAT] >= 3'd5) |-> (!res_found && res_flags == '0)); // R10
endmodule

bind asa_sibling_search asa_sibling_search_chk #(
    .NSLOT(NSLOT),
    .CW   (CW),
    .LAT  (LVL + 1)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .res_valid(res_valid),
    .res_flags(res_flags),
    .res_code (res_code),
    .res_found(res_found)
);

// File: tb/asa_sibling_search_bench.sv
// Bench: behavioural table model, expected results queued with their due
// cycle and compared against the outputs on every clock.
module asa_sibling_search_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 8;
    localparam int NDIG  = 4;
    localparam int DIGW  = 4;
    localparam int CW    = NDIG * DIGW;
    localparam int LAT   = $clog2(NSLOT) + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ld_clear = 1'b0, ld_valid = 1'b0;
    logic [CW-1:0]    ld_code = '0;
    logic             op_valid = 1'b0;
    logic [2:0]       op_kind = '0;
    logic [CW-1:0]    op_ref = '0;
    logic             res_valid;
    logic [NSLOT-1:0] res_flags;
    logic [CW-1:0]    res_code;
    logic             res_found;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_tag = "";

    logic [CW-1:0] m_code [NSLOT];
    logic          m_vld  [NSLOT];
    int            m_ptr = 0;

    int               q_due   [$];
    logic [NSLOT-1:0] q_flags [$];
    logic [CW-1:0]    q_code  [$];
    logic             q_found [$];
    string            q_tag   [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    asa_sibling_search #(.NSLOT(NSLOT), .NDIG(NDIG), .DIGW(DIGW)) u_asa_sibling_search (
        .clk(clk), .rst_n(rst_n), .ld_clear(ld_clear), .ld_valid(ld_valid), .ld_code(ld_code),
        .op_valid(op_valid), .op_kind(op_kind), .op_ref(op_ref),
        .res_valid(res_valid), .res_flags(res_flags), .res_code(res_code), .res_found(res_found)
    );

    function automatic logic [CW-1:0] mk(input int a, input int b, input int c, input int d);
        return {4'(a), 4'(b), 4'(c), 4'(d)};
    endfunction

    function automatic int dg(input logic [CW-1:0] c, input int k);
        return int'(c[CW-1-k*DIGW -: DIGW]);
    endfunction

    // Behavioural answer to a query against the current model table.
    task automatic model_op(input logic [2:0] k, input logic [CW-1:0] r,
                            output logic [NSLOT-1:0] fl, output logic [CW-1:0] cd,
                            output logic fd, output string tg);
        int rp, rd, bn, bp, bnd, bpd, sd;
        bit same;
        rp = -1; bn = -1; bp = -1; bnd = 0; bpd = 0;
        for (int i = 0; i < NDIG; i++) if (dg(r, i) != 0) rp = i;
        rd = (rp >= 0) ? dg(r, rp) : 0;
        for (int s = 0; s < NSLOT; s++) begin
            if (m_vld[s] && rp >= 0) begin
                same = 1;
                for (int i = 0; i < NDIG; i++) if (i != rp && dg(m_code[s], i) != dg(r, i)) same = 0;
                sd = dg(m_code[s], rp);
                if (same && sd > rd && (bn < 0 || sd < bnd)) begin bn = s; bnd = sd; end
                if (same && sd != 0 && sd < rd && (bp < 0 || sd > bpd)) begin bp = s; bpd = sd; end
            end
        end
        fl = '0; cd = '0; fd = 0;
        case (k)
            3'd0: begin if (bn >= 0) fl[bn] = 1; fd = (bn >= 0); tg = "R4"; end
            3'd1: begin if (bp >= 0) fl[bp] = 1; fd = (bp >= 0); tg = "R5"; end
            3'd2: begin if (bn >= 0) fl[bn] = 1; if (bp >= 0) fl[bp] = 1;
                        fd = (bn >= 0) || (bp >= 0); tg = "R6"; end
            3'd3: begin if (bn >= 0) cd = m_code[bn]; fd = (bn >= 0); tg = "R7"; end
            3'd4: begin if (bp >= 0) cd = m_code[bp]; fd = (bp >= 0); tg = "R7"; end
            default: tg = "R10";
        endcase
        if (!fd && k <= 3'd4) tg = "R8";
        if (cur_tag != "") tg = cur_tag;
    endtask

    // Model update: answer queries on the old table, then apply load/clear (R11).
    always @(posedge clk) begin
        logic [NSLOT-1:0] fl;
        logic [CW-1:0]    cd;
        logic             fd;
        string            tg;
        cyc++;
        if (!rst_n) begin
            for (int s = 0; s < NSLOT; s++) m_vld[s] = 0;
            m_ptr = 0;
        end else begin
            if (op_valid) begin
                model_op(op_kind, op_ref, fl, cd, fd, tg);
                q_due.push_back(cyc + LAT);
                q_flags.push_back(fl); q_code.push_back(cd);
                q_found.push_back(fd); q_tag.push_back(tg);
            end
            if (ld_clear) begin
                for (int s = 0; s < NSLOT; s++) m_vld[s] = 0;
                m_ptr = 0;
            end else if (ld_valid && m_ptr < NSLOT) begin
                m_code[m_ptr] = ld_code; m_vld[m_ptr] = 1; m_ptr++;
            end
        end
    end

    // Compare outputs against the model away from the active edge.
    always @(negedge clk) begin
        logic             ev, ef;
        logic [NSLOT-1:0] efl;
        logic [CW-1:0]    ecd;
        string            tg;
        if (cyc > 0) begin
            ev = 0; efl = '0; ecd = '0; ef = 0;
            tg = (rst_n) ? "R10" : "R10 reset";
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                ev = 1; efl = q_flags[0]; ecd = q_code[0]; ef = q_found[0]; tg = q_tag[0];
                void'(q_due.pop_front()); void'(q_flags.pop_front()); void'(q_code.pop_front());
                void'(q_found.pop_front()); void'(q_tag.pop_front());
            end
            checks++;
            if (res_valid !== ev || res_flags !== efl || res_code !== ecd || res_found !== ef) begin
                errors++;
                $display("FAIL %s cyc=%0d actual v=%b f=%b c=%h r=%b expected v=%b f=%b c=%h r=%b",
                         tg, cyc, res_valid, res_flags, res_code, res_found, ev, efl, ecd, ef);
            end
        end
    end

    task automatic step(input logic ldv, input logic [CW-1:0] ldc, input logic clr,
                        input logic opv, input logic [2:0] k, input logic [CW-1:0] r);
        ld_valid = ldv; ld_code = ldc; ld_clear = clr;
        op_valid = opv; op_kind = k; op_ref = r;
        @(negedge clk);
    endtask

    task automatic load(input logic [CW-1:0] c);
        step(1, c, 0, 0, 0, '0);
    endtask

    task automatic query(input logic [2:0] k, input logic [CW-1:0] r);
        step(0, '0, 0, 1, k, r);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, '0);
    endtask

    function automatic logic [CW-1:0] rnd_code();
        int dep;
        logic [CW-1:0] c;
        dep = 1 + int'($urandom % 3);
        c = '0;
        for (int i = 0; i < NDIG; i++)
            if (i < dep) c[CW-1-i*DIGW -: DIGW] = DIGW'(1 + $urandom % 3);
        return c;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: query on an empty table finds nothing.
        cur_tag = "R1";
        query(0, mk(1,2,3,0));
        // Fill all eight slots; slot 7 duplicates slot 1 for the R5 tie.
        load(mk(1,2,1,0)); load(mk(1,2,5,0)); load(mk(1,1,0,0)); load(mk(1,2,3,0));
        load(mk(1,3,0,0)); load(mk(2,0,0,0)); load(mk(1,2,4,1)); load(mk(1,2,5,0));
        load(mk(1,2,4,0));              // R1: ninth load must be dropped
        query(0, mk(1,2,3,0));          // R1: must pick slot 1, not the dropped 1.2.4
        cur_tag = "";
        // R4..R7, R9: all kinds back to back on one reference.
        for (int k = 0; k < 5; k++) query(3'(k), mk(1,2,3,0));
        query(1, mk(1,2,6,0));          // R5 tie: slots 1 and 7 both hold digit 5
        query(2, mk(1,2,4,0));          // R6: both sides flagged
        query(3, mk(1,2,5,0));          // R8: nothing on the right
        query(1, mk(1,2,1,0));          // R8: nothing on the left
        cur_tag = "R2";
        query(3, mk(1,0,0,0));          // depth 1: next top-level code is 2
        query(4, mk(1,0,0,0));
        cur_tag = "R3";
        query(3, mk(1,2,0,0));          // depth 2 siblings only
        query(4, mk(1,2,0,0));
        query(2, mk(1,2,4,1));          // no siblings of a lone leaf
        query(0, mk(0,0,0,0));          // root reference has no candidates
        cur_tag = "";
        query(5, mk(1,2,3,0));          // R10 unused kinds
        query(7, mk(1,2,3,0));
        idle(LAT + 2);
        // R11: clear and query in the same cycle, then load and query together.
        cur_tag = "R11";
        step(0, '0, 1, 1, 2, mk(1,2,3,0));
        step(1, mk(1,2,2,0), 0, 1, 1, mk(1,2,3,0));
        load(mk(1,2,7,0));
        query(2, mk(1,2,3,0));
        idle(LAT + 2);
        cur_tag = "";
        // Random mix of loads, clears and queries.
        for (int it = 0; it < 600; it++) begin
            int sel;
            sel = int'($urandom % 40);
            if (sel == 0)       step(0, '0, 1, 0, 0, '0);
            else if (sel < 14)  step(1, rnd_code(), 0, ($urandom % 2) == 1, 3'($urandom % 6), rnd_code());
            else if (sel < 36)  query(3'($urandom % 6), rnd_code());
            else                idle(1);
        end
        idle(LAT + 3);
        checks++;
        if (q_due.size() != 0) begin
            errors++;
            $display("FAIL R9 pending results actual=%0d expected=0", q_due.size());
        end
        summary();
        $finish;
    end
endmodule